// File: doc/BRIEF.md
# Sprite-Table and Sample-Fetch DMA Controller

This controller sits between a CPU bus and two DMA requesters. It stops the CPU with a ready line and takes over the address bus for its own transfers. A sprite-table transfer starts when the CPU writes a page number to a trigger register. It then copies 256 bytes, starting at offset zero of that page, into the data port of the sprite memory. Each transfer is a read on a get cycle followed by a write on the next put cycle. A sample transfer fetches one byte from an externally supplied address. It can take a cycle away from the CPU or from a sprite transfer that is already running.

The halt is requested as soon as the trigger arrives. The bus is taken only once the CPU reaches a read cycle, and that first halted read is left to the CPU as a dummy read. A sample fetch costs the CPU four halted cycles when it comes from the channel's bit counter running out. It costs three when it comes from an enable-register write, and in that case it starts a parameterised number of cycles after the write. The clock is the CPU cycle clock. `phase_get` marks get cycles.

Top module: `spr_smp_dma`

## Requirements
- R1: After reset, `cpu_rdy` is 1, `dma_drive` is 0, and `smp_valid` and `spr_done` are 0.
- R2: A CPU write (`cpu_rd`=0) to `PAGE_ADDR` pulls `cpu_rdy` low from the next cycle. While the CPU keeps writing, the controller drives no DMA bus cycle. The first halted cycle in which `cpu_rd`=1 is a dummy read with `dma_drive`=0.
- R3: The sprite page is the data of the last trigger write before the halted dummy read, so the result write of a double write wins. Trigger writes made while the transfer is running have no effect.
- R4: The sprite transfer reads `{page,8'h00}+i` for i = 0..255 in order, only when `phase_get`=1. Each byte is written with unchanged data to `PORT_ADDR` (`dma_rd`=0) on the following cycle, which has `phase_get`=0.
- R5: A sprite transfer with no sample fetch keeps `cpu_rdy` low for W+513 cycles when the dummy read falls on a put cycle and W+514 when it falls on a get cycle. W is the number of CPU write cycles between the first trigger write and the dummy read. `spr_done` pulses once, in the cycle after the final port write.
- R6: A one-cycle `smp_req` pulse keeps `cpu_rdy` low for exactly 4 cycles, starting the next cycle. The last of those cycles reads `smp_addr`. In the cycle after that read, `smp_valid`=1 and `smp_data` holds the byte read.
- R7: A CPU write to `EN_ADDR` with data bit `EN_BIT`=1 lowers `cpu_rdy` exactly `KICK_DLY`+1 cycles after the write. It then holds `cpu_rdy` low for 3 cycles and delivers one sample byte. The same write with bit `EN_BIT`=0 causes no halt and no sample.
- R8: A sample request during a sprite transfer takes the first get cycle after its wait, ahead of the sprite read. The sprite address sequence stays intact with no skipped or repeated byte, the halt grows by exactly 2 cycles, and exactly one sample byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | 1 = CPU read cycle, 0 = CPU write cycle |
| phase_get | input | 1 | 1 = get cycle, 0 = put cycle |
| cpu_rdy | output | 1 | CPU ready; 0 halts the CPU at its next read |
| dma_drive | output | 1 | DMA owns the bus this cycle |
| dma_rd | output | 1 | Direction of the DMA cycle, 1 = read |
| dma_addr | output | 16 | DMA address |
| dma_wdata | output | 8 | DMA write data |
| bus_rdata | input | 8 | Bus read data for DMA reads |
| smp_req | input | 1 | Sample bit counter ran out (one-cycle pulse) |
| smp_addr | input | 16 | Address of the next sample byte |
| smp_valid | output | 1 | Sample byte strobe |
| smp_data | output | 8 | Fetched sample byte |
| spr_done | output | 1 | One-cycle pulse after a finished sprite transfer |

## Verification
The hardest situation to reach is a sample fetch that lands in the middle of a running sprite transfer. The sprite byte order and the stall must then be judged together. The bench starts sprite transfers on both phase parities and pulses `smp_req` a fixed number of cycles into the run. It tracks every DMA read and port write against the page arithmetic and expects exactly two extra halted cycles. A second awkward case is the double trigger write of a read-modify-write. The bench issues two back-to-back trigger writes with different pages, then checks that the halt counts from the first write while every byte comes from the second page.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } halt_st_t;

    typedef struct packed {
        logic        drive;
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  wdata;
    } bus_req_t;

    localparam int RELOAD_STALL = 4;
    localparam int ENABLE_STALL = 3;

    // wait cycles in RUN before the sample read: stall minus dummy and read cycle
    function automatic logic [1:0] smp_pre_wait(input logic from_enable);
        return from_enable ? 2'(ENABLE_STALL - 2) : 2'(RELOAD_STALL - 2);
    endfunction

endpackage

// File: rtl/dma_smp_trig.sv
module dma_smp_trig
    import dma_ctl_pkg::*;
#(
    parameter int KICK_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic reload_req,
    input  logic enable_hit,
    input  logic run,
    input  logic take,
    output logic armed,
    output logic ready,
    output logic fire
);
    localparam int CW = $clog2(KICK_DLY + 1);

    logic [CW-1:0] dly;
    logic [1:0]    wcnt;

    assign fire  = (dly == CW'(1));
    assign ready = armed && (wcnt == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dly   <= '0;
            armed <= 1'b0;
            wcnt  <= 2'd0;
        end else begin
            if (enable_hit)
                dly <= CW'(KICK_DLY);
            else if (dly != '0)
                dly <= dly - 1'b1;

            if ((reload_req || fire) && (!armed || take)) begin
                armed <= 1'b1;
                wcnt  <= smp_pre_wait(!reload_req);
            end else if (take) begin
                armed <= 1'b0;
            end else if (run && armed && wcnt != 2'd0) begin
                wcnt <= wcnt - 2'd1;
            end
        end
    end
endmodule

// File: rtl/dma_spr_seq.sv
module dma_spr_seq #(
    parameter int LEN = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        page_hit,
    input  logic [7:0]  page_in,
    input  logic        lock,
    input  logic        rd_step,
    input  logic        wr_step,
    input  logic [7:0]  rd_data,
    output logic        act,
    output logic        full,
    output logic        last,
    output logic [15:0] src_addr,
    output logic [7:0]  hold_byte
);
    localparam int CW = $clog2(LEN) + 1;

    logic [7:0]    page;
    logic [CW-1:0] cnt;

    assign last     = (cnt == CW'(LEN));
    assign src_addr = {page, 8'h00} + 16'(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            page      <= 8'h00;
            cnt       <= '0;
            act       <= 1'b0;
            full      <= 1'b0;
            hold_byte <= 8'h00;
        end else if (page_hit && !lock) begin
            page <= page_in;
            act  <= 1'b1;
            cnt  <= '0;
            full <= 1'b0;
        end else begin
            if (rd_step) begin
                hold_byte <= rd_data;
                full      <= 1'b1;
                cnt       <= cnt + 1'b1;
            end
            if (wr_step) begin
                full <= 1'b0;
                if (last)
                    act <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spr_smp_dma.sv
module spr_smp_dma
    import dma_ctl_pkg::*;
#(
    parameter logic [15:0] PAGE_ADDR     = 16'h7F00,
    parameter logic [15:0] EN_ADDR       = 16'h7F01,
    parameter int          EN_BIT        = 4,
    parameter logic [15:0] SPR_PORT_ADDR = 16'h6004,
    parameter int          KICK_DLY      = 2,
    parameter int          SPR_LEN       = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        phase_get,
    output logic        cpu_rdy,
    output logic        dma_drive,
    output logic        dma_rd,
    output logic [15:0] dma_addr,
    output logic [7:0]  dma_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic        smp_req,
    input  logic [15:0] smp_addr,
    output logic        smp_valid,
    output logic [7:0]  smp_data,
    output logic        spr_done
);
    halt_st_t st, st_nx;
    bus_req_t bus;

    logic page_hit, en_hit, run;
    logic smp_armed, smp_ready, smp_fire, smp_take;
    logic spr_act, spr_full, spr_last, spr_rd, spr_wr;
    logic busy_after;
    logic [15:0] spr_src;
    logic [7:0]  spr_byte;

    assign page_hit = !cpu_rd && (cpu_addr == PAGE_ADDR);
    assign en_hit   = !cpu_rd && (cpu_addr == EN_ADDR) && cpu_wdata[EN_BIT];
    assign run      = (st == ST_RUN);

    dma_smp_trig #(.KICK_DLY(KICK_DLY)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .reload_req (smp_req),
        .enable_hit (en_hit),
        .run        (run),
        .take       (smp_take),
        .armed      (smp_armed),
        .ready      (smp_ready),
        .fire       (smp_fire)
    );

    dma_spr_seq #(.LEN(SPR_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .page_hit  (page_hit),
        .page_in   (cpu_wdata),
        .lock      (run),
        .rd_step   (spr_rd),
        .wr_step   (spr_wr),
        .rd_data   (bus_rdata),
        .act       (spr_act),
        .full      (spr_full),
        .last      (spr_last),
        .src_addr  (spr_src),
        .hold_byte (spr_byte)
    );

    // sample wins the get cycle; alone it ignores the phase
    assign smp_take = run && smp_ready && (phase_get || !spr_act);
    assign spr_rd   = run && spr_act && !spr_full && phase_get && !smp_take;
    assign spr_wr   = run && spr_act && spr_full && !phase_get;

    assign busy_after = (spr_act && !(spr_wr && spr_last))
                      || (smp_armed && !smp_take)
                      || smp_req || smp_fire;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (page_hit || smp_req || smp_fire) st_nx = ST_HOLD;
            ST_HOLD: if (cpu_rd) st_nx = ST_RUN;
            ST_RUN:  if (!busy_after) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        bus = '0;
        if (smp_take) begin
            bus.drive = 1'b1;
            bus.rd    = 1'b1;
            bus.addr  = smp_addr;
        end else if (spr_rd) begin
            bus.drive = 1'b1;
            bus.rd    = 1'b1;
            bus.addr  = spr_src;
        end else if (spr_wr) begin
            bus.drive = 1'b1;
            bus.rd    = 1'b0;
            bus.addr  = SPR_PORT_ADDR;
            bus.wdata = spr_byte;
        end
    end

    assign cpu_rdy   = (st == ST_IDLE);
    assign dma_drive = bus.drive;
    assign dma_rd    = bus.rd;
    assign dma_addr  = bus.addr;
    assign dma_wdata = bus.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            smp_valid <= 1'b0;
            smp_data  <= 8'h00;
            spr_done  <= 1'b0;
        end else begin
            st        <= st_nx;
            smp_valid <= smp_take;
            if (smp_take)
                smp_data <= bus_rdata;
            spr_done  <= spr_wr && spr_last;
        end
    end
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
    parameter logic [15:0] PORT_ADDR = 16'h6004
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_rdy,
    input logic        cpu_rd,
    input logic        phase_get,
    input logic        dma_drive,
    input logic        dma_rd,
    input logic [15:0] dma_addr,
    input logic        smp_valid,
    input logic        spr_done
);
    // R2
    dummy_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rdy) |-> !dma_drive);

    // R2
    halt_before_bus_chk: assert property (@(posedge clk) disable iff (rst)
        dma_drive |-> $past(!cpu_rdy));

    // R4
    port_write_put_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_drive && !dma_rd) |-> (dma_addr == PORT_ADDR && !phase_get));

    // R6
    smp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(dma_drive && dma_rd));

    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        spr_done |-> $past(dma_drive && !dma_rd));

    // R2
    no_bus_on_cpu_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_drive && !cpu_rdy && $fell(cpu_rdy)) |-> cpu_rd);
endmodule

bind spr_smp_dma dma_ctl_chk #(.PORT_ADDR(SPR_PORT_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_rdy   (cpu_rdy),
    .cpu_rd    (cpu_rd),
    .phase_get (phase_get),
    .dma_drive (dma_drive),
    .dma_rd    (dma_rd),
    .dma_addr  (dma_addr),
    .smp_valid (smp_valid),
    .spr_done  (spr_done)
);

// File: tb/sim_spr_smp_dma.sv
module sim_spr_smp_dma;
    localparam int          KD   = 2;
    localparam int          EB   = 4;
    localparam logic [15:0] PG_A = 16'h7F00;
    localparam logic [15:0] EN_A = 16'h7F01;
    localparam logic [15:0] PT_A = 16'h6004;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0200;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_rd = 1'b1;
    logic        phase_get = 1'b0;
    logic        cpu_rdy, dma_drive, dma_rd, smp_valid, spr_done;
    logic [15:0] dma_addr;
    logic [7:0]  dma_wdata, bus_rdata, smp_data;
    logic        smp_req = 1'b0;
    logic [15:0] smp_addr = 16'hC123;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
    endfunction

    assign bus_rdata = pat(dma_addr);

    spr_smp_dma #(
        .PAGE_ADDR(PG_A), .EN_ADDR(EN_A), .EN_BIT(EB),
        .SPR_PORT_ADDR(PT_A), .KICK_DLY(KD), .SPR_LEN(256)
    ) u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .phase_get(phase_get), .cpu_rdy(cpu_rdy),
        .dma_drive(dma_drive), .dma_rd(dma_rd), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .bus_rdata(bus_rdata), .smp_req(smp_req),
        .smp_addr(smp_addr), .smp_valid(smp_valid), .smp_data(smp_data),
        .spr_done(spr_done)
    );

    int checks = 0, fails = 0, cyc = 0;
    int low_cnt, first_low, drv_in_dummy, drv_while_wr;
    int wk, rk, bad_wr, bad_rd, smp_hits, done_cnt, done_cyc, last_wr_cyc;
    logic [7:0]  smp_last;
    logic [15:0] exp_base;
    bit late_zone = 1'b0;
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (!cpu_rdy) begin
                low_cnt++;
                if (first_low < 0) begin
                    first_low = cyc;
                    if (dma_drive) drv_in_dummy++;
                end
            end
            if (dma_drive && !cpu_rd && !late_zone) drv_while_wr++;
            if (dma_drive && !dma_rd) begin
                if (dma_addr != PT_A || phase_get || dma_wdata != pat(exp_base + 16'(wk)))
                    bad_wr++;
                wk++;
                last_wr_cyc = cyc;
            end
            if (dma_drive && dma_rd && dma_addr != smp_addr) begin
                if (dma_addr != exp_base + 16'(rk) || !phase_get) bad_rd++;
                rk++;
            end
            if (smp_valid) begin
                smp_hits++;
                smp_last = smp_data;
            end
            if (spr_done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1 phase_get = ~phase_get;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_stats();
        low_cnt = 0; first_low = -1; drv_in_dummy = 0; drv_while_wr = 0;
        wk = 0; rk = 0; bad_wr = 0; bad_rd = 0; smp_hits = 0;
        done_cnt = 0; done_cyc = -1; last_wr_cyc = -1; smp_last = 8'h00;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, output int wc);
        cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d;
        wc = cyc + 1;
        step();
        cpu_rd = 1'b1; cpu_addr = 16'h0200; cpu_wdata = 8'h00;
    endtask

    task automatic wait_phase(input bit ph);
        while (phase_get != ph) step();
    endtask

    task automatic wait_idle();
        int n = 0;
        step();
        while (!cpu_rdy && n < 3000) begin
            step();
            n++;
        end
        repeat (4) step();
    endtask

    task automatic run_sprite(input logic [7:0] pg, input bit ph, input int extra,
                              input bit rmw, input int smp_at, input bit late);
        int t0, tw, w, exp_low;
        bit dph;
        clear_stats();
        exp_base = {pg, 8'h00};
        wait_phase(ph);
        if (rmw) begin
            cpu_write(PG_A, pg ^ 8'h55, t0);
            cpu_write(PG_A, pg, tw);
        end else begin
            cpu_write(PG_A, pg, t0);
        end
        for (int i = 0; i < extra; i++) cpu_write(16'h0300, 8'hA5, tw);
        w = extra + (rmw ? 1 : 0);
        dph = ph ^ bit'((1 + w) % 2);
        exp_low = w + (dph ? 514 : 513) + (smp_at > 0 ? 2 : 0);
        if (smp_at > 0) begin
            repeat (smp_at) step();
            smp_req = 1'b1;
            step();
            smp_req = 1'b0;
        end
        if (late) begin
            repeat (30) step();
            late_zone = 1'b1;
            cpu_rd = 1'b0; cpu_addr = PG_A; cpu_wdata = 8'hEE;
            step();
            cpu_rd = 1'b1; cpu_addr = 16'h0200;
            late_zone = 1'b0;
        end
        wait_idle();
        // R2
        chk(first_low == t0 + 1, "R2 halt start", first_low, t0 + 1);
        chk(drv_in_dummy == 0, "R2 dummy read", drv_in_dummy, 0);
        chk(drv_while_wr == 0, "R2 bus during cpu write", drv_while_wr, 0);
        // R5 / R8
        chk(low_cnt == exp_low, smp_at > 0 ? "R8 halt length" : "R5 halt length", low_cnt, exp_low);
        // R4 / R3
        chk(rk == 256, "R4 read count", rk, 256);
        chk(wk == 256, "R4 write count", wk, 256);
        chk(bad_rd == 0, rmw ? "R3 page from last write" : (late ? "R3 late write" : "R4 read order"), bad_rd, 0);
        chk(bad_wr == 0, "R4 port data", bad_wr, 0);
        // R5
        chk(done_cnt == 1, "R5 done pulses", done_cnt, 1);
        chk(done_cyc == last_wr_cyc + 1, "R5 done timing", done_cyc, last_wr_cyc + 1);
        // R8
        chk(smp_hits == (smp_at > 0 ? 1 : 0), "R8 sample count", smp_hits, smp_at > 0 ? 1 : 0);
        if (smp_at > 0)
            chk(smp_last == pat(smp_addr), "R8 sample data", smp_last, pat(smp_addr));
    endtask

    task automatic run_reload(input logic [15:0] a);
        int t0;
        clear_stats();
        smp_addr = a;
        smp_req = 1'b1;
        t0 = cyc + 1;
        step();
        smp_req = 1'b0;
        repeat (10) step();
        // R6
        chk(first_low == t0 + 1, "R6 halt start", first_low, t0 + 1);
        chk(low_cnt == 4, "R6 halt length", low_cnt, 4);
        chk(smp_hits == 1, "R6 sample count", smp_hits, 1);
        chk(smp_last == pat(a), "R6 sample data", smp_last, pat(a));
        chk(done_cnt == 0 && wk == 0, "R6 no sprite activity", done_cnt + wk, 0);
    endtask

    task automatic run_enable(input logic [15:0] a, input bit bit_set);
        int t0;
        logic [7:0] d;
        clear_stats();
        smp_addr = a;
        d = bit_set ? (8'h01 << EB) : ~(8'h01 << EB);
        cpu_write(EN_A, d, t0);
        repeat (KD + 10) step();
        if (bit_set) begin
            // R7
            chk(first_low == t0 + KD + 1, "R7 delayed start", first_low, t0 + KD + 1);
            chk(low_cnt == 3, "R7 halt length", low_cnt, 3);
            chk(smp_hits == 1, "R7 sample count", smp_hits, 1);
            chk(smp_last == pat(a), "R7 sample data", smp_last, pat(a));
        end else begin
            chk(low_cnt == 0, "R7 cleared bit no halt", low_cnt, 0);
            chk(smp_hits == 0, "R7 cleared bit no sample", smp_hits, 0);
        end
    endtask

    initial begin
        clear_stats();
        exp_base = 16'h0000;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        step();
        // R1
        chk(cpu_rdy == 1'b1, "R1 ready after reset", int'(cpu_rdy), 1);
        chk(dma_drive == 1'b0, "R1 bus idle after reset", int'(dma_drive), 0);
        chk(smp_valid == 1'b0 && spr_done == 1'b0, "R1 strobes after reset",
            int'(smp_valid) + int'(spr_done), 0);

        foreach (smp_addr[i]) begin end
        for (int p = 0; p < 2; p++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int ex = 0; ex < 3; ex += 2) begin
                    run_sprite(p ? 8'h13 : 8'h02, bit'(ph), ex, 1'b0, 0, 1'b0);
                end
            end
        end
        run_sprite(8'h21, 1'b0, 0, 1'b1, 0, 1'b0);
        run_sprite(8'h34, 1'b1, 0, 1'b1, 0, 1'b0);
        run_sprite(8'h05, 1'b0, 0, 1'b0, 0, 1'b1);
        smp_addr = 16'hC123;
        run_sprite(8'h07, 1'b0, 0, 1'b0, 40, 1'b0);
        run_sprite(8'h08, 1'b1, 0, 1'b0, 41, 1'b0);

        for (int k = 0; k < 4; k++) run_reload(16'hC000 + 16'(k * 37));
        for (int k = 0; k < 3; k++) run_enable(16'hD100 + 16'(k * 11), 1'b1);
        run_enable(16'hD200, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule